// File: doc/BRIEF.md
# Barrel Shifter With Carry

This block is the second-operand path of a 32-bit RISC datapath. From an operand, a shift kind, a shift amount and the incoming carry flag, it forms a shifted value and a shifter carry-out. An ALU consumes the value. A flag stage consumes the carry. The per-kind carry rules for amounts of zero, exactly the word width, and beyond the word width are all built in. So is a one-bit rotate through the carry flag.

A front end picks where the operand and amount come from. In immediate mode an already-rotated constant passes straight through. The other two modes shift a source register, either by a 5-bit field from the instruction word or by the low byte of a second register. When the source register is the program counter, the front end adds the pipeline read-ahead to its value first: 8 in 32-bit instruction state and 4 in 16-bit state. An optional output register, chosen by a parameter, adds one cycle of latency and a valid flag that follows the request.

Top module: `bshift_unit`

## Requirements
- R1: With `op_mode` = 0 (immediate), `result` equals `imm_val` and `carry_out` equals `carry_in`, whatever `shift_kind` holds.
- R2: With `op_mode` = 1, the amount is `imm_amt` (0 to 31). With `op_mode` = 2, the amount is `amt_byte` (0 to 255). With `op_mode` = 3, `result` is all ones and `carry_out` equals `carry_in`.
- R3: `shift_kind` encodes 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, and 4 one-bit rotate through carry. Codes 5 to 7 give `result` 0 and `carry_out` = `carry_in`.
- R4: For kinds 0 to 3, an amount of zero returns the operand unchanged, with `carry_out` = `carry_in`.
- R5: A logical left shift by n in 1..32 gives carry bit (32 − n) of the operand. For n above 32, the result and carry are both 0.
- R6: A logical right shift by n in 1..32 gives carry bit (n − 1) of the operand. For n above 32, the result and carry are both 0.
- R7: An arithmetic right shift fills from bit 31 and gives carry bit (n − 1). For n of 32 or more, the result is 32 copies of bit 31 and the carry is bit 31.
- R8: A rotate right by a nonzero n rotates by n mod 32, and `carry_out` equals bit 31 of the result. A multiple of 32 leaves the value unchanged.
- R9: The rotate through carry ignores the amount. It shifts right by one, puts `carry_in` into bit 31, and outputs the old bit 0 as the carry.
- R10: When `src_is_pc` is 1, the operand is `src_val` + 8. If `narrow_state` is also 1, it is `src_val` + 4 instead. The sum wraps modulo 2^32 and is taken before shifting.
- R11: With the output register in place, a request accepted on one rising edge shows on the outputs after that edge, with `out_valid` = 1. A cycle with no request gives `out_valid` = 0. Reset clears `out_valid`, `result` and `carry_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op_mode | input | 2 | Operand source: 0 immediate, 1 shift by field, 2 shift by register byte, 3 reserved |
| shift_kind | input | 3 | Shift kind code |
| imm_val | input | 32 | Pre-rotated immediate constant |
| src_val | input | 32 | Source register value |
| src_is_pc | input | 1 | Source register is the program counter |
| narrow_state | input | 1 | 16-bit instruction state (PC read-ahead 4, not 8) |
| imm_amt | input | 5 | Shift amount from the instruction word |
| amt_byte | input | 8 | Low byte of the amount register |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result present |
| result | output | 32 | Shifted operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Every cycle, the assertions check the carry rules at the edges of the amount range: the zero-amount pass-through, saturation of the logical shifts to zero, the all-sign result of large arithmetic shifts, the link between rotate carry and result bit 31, and the bit placement of the rotate through carry. They also check the one-cycle timing of the registered outputs and immediate-mode transparency. Only the bench's scenarios can show the exact carry bit chosen for amounts inside the range. The same holds for the program-counter read-ahead in both instruction states, the choice of amount source per mode, and the handling of the reserved mode and reserved kind codes. The bench checks these against an independent step-by-step model that shifts one bit at a time.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    typedef enum logic [2:0] {
        SH_LSL = 3'd0,
        SH_LSR = 3'd1,
        SH_ASR = 3'd2,
        SH_ROR = 3'd3,
        SH_RRX = 3'd4
    } shift_kind_e;

    typedef enum logic [1:0] {
        OPM_IMM     = 2'd0,
        OPM_REG_IMM = 2'd1,
        OPM_REG_REG = 2'd2,
        OPM_RSVD    = 2'd3
    } op_mode_e;

endpackage

// File: rtl/bshift_opsel.sv
module bshift_opsel
    import bshift_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int AMT_W      = 8,
    parameter int FIELD_W    = 5,
    parameter int WIDE_OFS   = 8,
    parameter int NARROW_OFS = 4
) (
    input  logic [1:0]        op_mode,
    input  logic [DATA_W-1:0] src_val,
    input  logic              src_is_pc,
    input  logic              narrow_state,
    input  logic [FIELD_W-1:0] imm_amt,
    input  logic [AMT_W-1:0]  amt_byte,
    output logic [DATA_W-1:0] sel_operand,
    output logic [AMT_W-1:0]  sel_amount
);

    localparam logic [DATA_W-1:0] WIDE_K   = DATA_W'(WIDE_OFS);
    localparam logic [DATA_W-1:0] NARROW_K = DATA_W'(NARROW_OFS);

    logic [DATA_W-1:0] pc_adj_d;

    always_comb begin
        // read-ahead of the program counter
        if (src_is_pc) begin
            pc_adj_d = narrow_state ? NARROW_K : WIDE_K;
        end else begin
            pc_adj_d = '0;
        end
        sel_operand = src_val + pc_adj_d;

        // amount source per mode
        case (op_mode)
            OPM_REG_IMM: sel_amount = AMT_W'(imm_amt);
            OPM_REG_REG: sel_amount = amt_byte;
            default:     sel_amount = '0;
        endcase
    end

endmodule

// File: rtl/bshift_core.sv
module bshift_core
    import bshift_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [2:0]        shift_kind,
    input  logic [DATA_W-1:0] operand,
    input  logic [AMT_W-1:0]  amount,
    input  logic              carry_in,
    output logic [DATA_W-1:0] core_res,
    output logic              core_cout
);

    localparam int                SH_W   = $clog2(DATA_W);
    localparam logic [AMT_W-1:0]  FULL_A = AMT_W'(DATA_W);
    localparam logic [SH_W:0]     FULL_S = (SH_W+1)'(DATA_W);

    logic [DATA_W:0]        ext_l_d;
    logic [DATA_W:0]        ext_r_d;
    logic signed [DATA_W:0] ext_a_d;
    logic [AMT_W-1:0]       asr_amt_d;
    logic [SH_W:0]          rot_d;
    logic [DATA_W-1:0]      ror_val_d;
    logic                   amt_zero_d;

    always_comb begin
        amt_zero_d = (amount == '0);

        // carry lands in the extra bit of a widened word
        ext_l_d   = {1'b0, operand} << amount;
        ext_r_d   = {operand, 1'b0} >> amount;
        asr_amt_d = (amount >= FULL_A) ? FULL_A : amount;
        ext_a_d   = $signed({operand, 1'b0}) >>> asr_amt_d;

        rot_d     = {1'b0, amount[SH_W-1:0]};
        ror_val_d = (operand >> rot_d) | (operand << (FULL_S - rot_d));

        core_res  = '0;
        core_cout = carry_in;
        case (shift_kind)
            SH_LSL: begin
                if (amt_zero_d) begin
                    core_res = operand;
                end else begin
                    core_res  = ext_l_d[DATA_W-1:0];
                    core_cout = ext_l_d[DATA_W];
                end
            end
            SH_LSR: begin
                if (amt_zero_d) begin
                    core_res = operand;
                end else begin
                    core_res  = ext_r_d[DATA_W:1];
                    core_cout = ext_r_d[0];
                end
            end
            SH_ASR: begin
                if (amt_zero_d) begin
                    core_res = operand;
                end else begin
                    core_res  = ext_a_d[DATA_W:1];
                    core_cout = ext_a_d[0];
                end
            end
            SH_ROR: begin
                if (amt_zero_d) begin
                    core_res = operand;
                end else begin
                    core_res  = ror_val_d;
                    core_cout = ror_val_d[DATA_W-1];
                end
            end
            SH_RRX: begin
                core_res  = {carry_in, operand[DATA_W-1:1]};
                core_cout = operand[0];
            end
            default: begin
                core_res  = '0;
                core_cout = carry_in;
            end
        endcase
    end

endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
    import bshift_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int AMT_W      = 8,
    parameter int FIELD_W    = 5,
    parameter int WIDE_OFS   = 8,
    parameter int NARROW_OFS = 4,
    parameter bit REG_OUT    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_mode,
    input  logic [2:0]        shift_kind,
    input  logic [DATA_W-1:0] imm_val,
    input  logic [DATA_W-1:0] src_val,
    input  logic              src_is_pc,
    input  logic              narrow_state,
    input  logic [FIELD_W-1:0] imm_amt,
    input  logic [AMT_W-1:0]  amt_byte,
    input  logic              carry_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              carry_out
);

    localparam int MSB = DATA_W - 1;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
        logic              cout;
    } stage_t;

    logic [DATA_W-1:0] sel_operand;
    logic [AMT_W-1:0]  sel_amount;
    logic [DATA_W-1:0] core_res;
    logic              core_cout;
    stage_t            st_d;

    bshift_opsel #(
        .DATA_W    (DATA_W),
        .AMT_W     (AMT_W),
        .FIELD_W   (FIELD_W),
        .WIDE_OFS  (WIDE_OFS),
        .NARROW_OFS(NARROW_OFS)
    ) u_opsel (
        .op_mode     (op_mode),
        .src_val     (src_val),
        .src_is_pc   (src_is_pc),
        .narrow_state(narrow_state),
        .imm_amt     (imm_amt),
        .amt_byte    (amt_byte),
        .sel_operand (sel_operand),
        .sel_amount  (sel_amount)
    );

    bshift_core #(
        .DATA_W(DATA_W),
        .AMT_W (AMT_W)
    ) u_core (
        .shift_kind(shift_kind),
        .operand   (sel_operand),
        .amount    (sel_amount),
        .carry_in  (carry_in),
        .core_res  (core_res),
        .core_cout (core_cout)
    );

    always_comb begin
        st_d.vld = in_valid;
        case (op_mode)
            OPM_IMM: begin
                st_d.res  = imm_val;
                st_d.cout = carry_in;
            end
            OPM_RSVD: begin
                st_d.res  = '1;
                st_d.cout = carry_in;
            end
            default: begin
                st_d.res  = core_res;
                st_d.cout = core_cout;
            end
        endcase
    end

    generate
        if (REG_OUT) begin : g_reg
            stage_t st_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign out_valid = st_q.vld;
            assign result    = st_q.res;
            assign carry_out = st_q.cout;

            p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
            p_imm_through_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op_mode == OPM_IMM) |=>
                    (result == $past(imm_val) && carry_out == $past(carry_in)));
        end else begin : g_comb
            assign out_valid = st_d.vld;
            assign result    = st_d.res;
            assign carry_out = st_d.cout;
        end
    endgenerate

    p_zero_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_kind <= 3'(SH_ROR) && sel_amount == '0) |->
            (core_res == sel_operand && core_cout == carry_in));

    p_lsl_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_kind == SH_LSL && sel_amount > AMT_W'(DATA_W)) |->
            (core_res == '0 && !core_cout));

    p_lsr_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_kind == SH_LSR && sel_amount > AMT_W'(DATA_W)) |->
            (core_res == '0 && !core_cout));

    p_asr_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_kind == SH_ASR && sel_amount >= AMT_W'(DATA_W)) |->
            (core_res == {DATA_W{sel_operand[MSB]}} && core_cout == sel_operand[MSB]));

    p_ror_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_kind == SH_ROR && sel_amount != '0) |->
            (core_cout == core_res[MSB]));

    p_rrx_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_kind == SH_RRX) |->
            (core_res[MSB] == carry_in && core_cout == sel_operand[0]));

endmodule

// File: tb/tb_bshift_unit.sv
`timescale 1ns/1ps
module tb_bshift_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_mode = '0;
    logic [2:0]  shift_kind = '0;
    logic [31:0] imm_val = '0;
    logic [31:0] src_val = '0;
    logic        src_is_pc = 1'b0;
    logic        narrow_state = 1'b0;
    logic [4:0]  imm_amt = '0;
    logic [7:0]  amt_byte = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        carry_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        c;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    bshift_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_mode(op_mode),
        .shift_kind(shift_kind), .imm_val(imm_val), .src_val(src_val),
        .src_is_pc(src_is_pc), .narrow_state(narrow_state), .imm_amt(imm_amt),
        .amt_byte(amt_byte), .carry_in(carry_in), .out_valid(out_valid),
        .result(result), .carry_out(carry_out)
    );

    task automatic check(input bit ok, input string tag, input logic [32:0] act,
                         input logic [32:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual carry/result=%h expected=%h", tag, act, exp);
        end
    endtask

    // one-bit-at-a-time reference, returns {carry, result}
    function automatic logic [32:0] model(input logic [2:0] k, input logic [31:0] v,
                                          input logic [7:0] a, input logic c);
        logic [31:0] x = v;
        logic        cy = c;
        case (k)
            3'd0: for (int i = 0; i < a; i++) begin cy = x[31]; x = {x[30:0], 1'b0}; end
            3'd1: for (int i = 0; i < a; i++) begin cy = x[0];  x = {1'b0, x[31:1]}; end
            3'd2: for (int i = 0; i < a; i++) begin cy = x[0];  x = {x[31], x[31:1]}; end
            3'd3: begin
                for (int i = 0; i < (a % 32); i++) x = {x[0], x[31:1]};
                if (a != 0) cy = x[31];
            end
            3'd4: begin cy = v[0]; x = {c, v[31:1]}; end
            default: begin x = '0; cy = c; end
        endcase
        return {cy, x};
    endfunction

    task automatic send(input logic [1:0] m, input logic [2:0] k, input logic [31:0] imm,
                        input logic [31:0] src, input bit pc, input bit nar,
                        input logic [4:0] ia, input logic [7:0] ab, input bit c,
                        input string tag);
        exp_t e;
        logic [31:0] opnd;
        logic [7:0]  amt;
        logic [32:0] r;
        opnd = src + (pc ? (nar ? 32'd4 : 32'd8) : 32'd0);
        amt  = (m == 2'd1) ? {3'b0, ia} : ab;
        if (m == 2'd0)      r = {c, imm};
        else if (m == 2'd3) r = {c, 32'hFFFF_FFFF};
        else                r = model(k, opnd, amt, c);
        e.res = r[31:0];
        e.c   = r[32];
        e.tag = tag;
        @(negedge clk);
        op_mode = m; shift_kind = k; imm_val = imm; src_val = src;
        src_is_pc = pc; narrow_state = nar; imm_amt = ia; amt_byte = ab;
        carry_in = c; in_valid = 1'b1;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: pops expected items as results appear
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R11 unexpected out_valid", {carry_out, result}, 33'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({carry_out, result} === {e.c, e.res}, e.tag,
                          {carry_out, result}, {e.c, e.res});
                end
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check({out_valid, carry_out, result} == '0, "R11 reset state",
              {carry_out, result}, 33'h0);
        rst_n = 1'b1;

        // R1 immediate mode ignores kind
        send(2'd0, 3'd2, 32'hF000_000F, 32'h1234_5678, 0, 0, 5'd7, 8'd9, 1, "R1 imm c1");
        send(2'd0, 3'd4, 32'h0000_00FF, 32'h0, 0, 0, 5'd0, 8'd0, 0, "R1 imm c0");
        // R2 reserved mode and amount sources
        send(2'd3, 3'd0, 32'h0, 32'h5555_5555, 0, 0, 5'd3, 8'd3, 0, "R2 reserved mode");
        send(2'd1, 3'd0, 32'h0, 32'h0000_0001, 0, 0, 5'd31, 8'd2, 0, "R2 field amount");
        send(2'd2, 3'd0, 32'h0, 32'h0000_0001, 0, 0, 5'd31, 8'd2, 0, "R2 byte amount");
        // R3 reserved kinds
        send(2'd2, 3'd5, 32'h0, 32'hFFFF_FFFF, 0, 0, 5'd0, 8'd4, 1, "R3 kind5");
        send(2'd1, 3'd7, 32'h0, 32'hFFFF_FFFF, 0, 0, 5'd4, 8'd0, 0, "R3 kind7");
        // R4 zero amount per kind
        for (int k = 0; k < 4; k++) begin
            send(2'd2, 3'(k), 32'h0, 32'h8000_0001, 0, 0, 5'd0, 8'd0, 1, "R4 zero amount");
        end
        // R5 logical left
        send(2'd2, 3'd0, 32'h0, 32'h8000_0003, 0, 0, 5'd0, 8'd1,   0, "R5 lsl 1");
        send(2'd2, 3'd0, 32'h0, 32'h0000_0003, 0, 0, 5'd0, 8'd31,  0, "R5 lsl 31");
        send(2'd2, 3'd0, 32'h0, 32'h0000_0001, 0, 0, 5'd0, 8'd32,  0, "R5 lsl 32");
        send(2'd2, 3'd0, 32'h0, 32'hFFFF_FFFF, 0, 0, 5'd0, 8'd33,  1, "R5 lsl 33");
        send(2'd2, 3'd0, 32'h0, 32'hFFFF_FFFF, 0, 0, 5'd0, 8'd255, 1, "R5 lsl 255");
        // R6 logical right
        send(2'd2, 3'd1, 32'h0, 32'h8000_0001, 0, 0, 5'd0, 8'd1,  0, "R6 lsr 1");
        send(2'd2, 3'd1, 32'h0, 32'h8000_0000, 0, 0, 5'd0, 8'd32, 0, "R6 lsr 32");
        send(2'd2, 3'd1, 32'h0, 32'hFFFF_FFFF, 0, 0, 5'd0, 8'd40, 1, "R6 lsr 40");
        // R7 arithmetic right
        send(2'd1, 3'd2, 32'h0, 32'h8000_0010, 0, 0, 5'd5,  8'd0,   0, "R7 asr 5");
        send(2'd2, 3'd2, 32'h0, 32'h8000_0000, 0, 0, 5'd0,  8'd32,  0, "R7 asr 32");
        send(2'd2, 3'd2, 32'h0, 32'h9000_0000, 0, 0, 5'd0,  8'd200, 0, "R7 asr 200");
        send(2'd2, 3'd2, 32'h0, 32'h7FFF_FFFF, 0, 0, 5'd0,  8'd40,  1, "R7 asr positive");
        // R8 rotate right
        send(2'd2, 3'd3, 32'h0, 32'h0000_000F, 0, 0, 5'd0, 8'd4,  0, "R8 ror 4");
        send(2'd2, 3'd3, 32'h0, 32'h8000_0000, 0, 0, 5'd0, 8'd32, 0, "R8 ror 32");
        send(2'd2, 3'd3, 32'h0, 32'h0000_0010, 0, 0, 5'd0, 8'd36, 1, "R8 ror 36");
        // R9 rotate through carry
        send(2'd1, 3'd4, 32'h0, 32'h0000_0003, 0, 0, 5'd9, 8'd0, 1, "R9 rrx c1");
        send(2'd2, 3'd4, 32'h0, 32'hFFFF_FFFE, 0, 0, 5'd0, 8'd7, 0, "R9 rrx c0");
        // R10 program counter read-ahead
        send(2'd1, 3'd0, 32'h0, 32'h0000_1000, 1, 0, 5'd0, 8'd0, 0, "R10 pc wide");
        send(2'd1, 3'd0, 32'h0, 32'h0000_1000, 1, 1, 5'd0, 8'd0, 0, "R10 pc narrow");
        send(2'd2, 3'd1, 32'h0, 32'hFFFF_FFFC, 1, 0, 5'd0, 8'd1, 0, "R10 pc wrap");
        idle();
        @(posedge clk);
        #1;
        check(out_valid == 1'b0, "R11 idle gap", {32'h0, out_valid}, 33'h0);

        // mixed stream
        for (int i = 0; i < 200; i++) begin
            logic [31:0] r1, r2;
            r1 = $urandom;
            r2 = $urandom;
            send(2'(r1[1:0]), 3'(r1[4:2]), r2, $urandom, r1[5], r1[6],
                 5'(r1[11:7]), 8'(r1[19:12]), r1[20], "R3 mixed stream");
        end
        idle();

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R11 all results seen", 33'(sb.size()), 33'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule